// File: doc/BRIEF.md
# Two-Wide Register Rename Stage

This block sits at the dispatch point of an out-of-order core. It maps a group of up to two instructions per cycle from 32 architectural registers onto a pool of 64 physical registers. Each instruction that writes a register receives a physical register no other in-flight write holds. This removes write-after-read and write-after-write hazards, and only true dependences remain visible to the issue logic.

Slot A is the older instruction of the group and slot B the younger. Sources are looked up in a mapping table before the destinations of the same group are applied to it. Slot B therefore compares its sources against slot A's destination and forwards slot A's fresh tag when they match.

Every renamed write also reports the physical register its destination used to map to. The reorder buffer keeps that old tag. When the instruction commits, the old tag comes back through one of two return ports and rejoins the free pool. A group for which the pool holds too few registers is held off as a whole. Recovery from mis-speculation is done by reset.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and exactly physical registers 32 to 63 are free.
- R2: Slot A's source tags equal the current mapping of the named architectural registers. Any source whose valid bit is low reports tag 0.
- R3: Renaming takes the lowest-numbered free physical registers. When both slots write, slot A receives the lower tag and slot B the next free one above it. When only one slot writes, that slot receives the lowest free tag.
- R4: Each writing slot reports as its old tag the mapping its destination held before the group. The table holds the new tag from the next clock edge on.
- R5: A valid slot B source that names slot A's destination, while slot A writes, reports slot A's new tag instead of the table entry. Non-matching slot B sources read the table.
- R6: If both slots write the same architectural register, slot B's old tag is slot A's new tag, and afterwards the table holds slot B's tag.
- R7: The stall output is high only while a group is presented and the free pool holds fewer registers than the number of writing slots. A stalled group changes neither the table nor the free pool.
- R8: A tag presented on either return port is free from the next cycle on and can be allocated by the following group.
- R9: With the group-valid input low, nothing is allocated and the table does not change, whatever the slot inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_vld | input | 1 | A rename group is presented |
| a_dst_vld | input | 1 | Slot A writes a register |
| a_dst | input | 5 | Slot A destination register |
| a_s0_vld | input | 1 | Slot A first source used |
| a_s0 | input | 5 | Slot A first source register |
| a_s1_vld | input | 1 | Slot A second source used |
| a_s1 | input | 5 | Slot A second source register |
| b_dst_vld | input | 1 | Slot B writes a register |
| b_dst | input | 5 | Slot B destination register |
| b_s0_vld | input | 1 | Slot B first source used |
| b_s0 | input | 5 | Slot B first source register |
| b_s1_vld | input | 1 | Slot B second source used |
| b_s1 | input | 5 | Slot B second source register |
| ret0_vld | input | 1 | Return port 0 frees a tag |
| ret0_tag | input | 6 | Tag freed on port 0 |
| ret1_vld | input | 1 | Return port 1 frees a tag |
| ret1_tag | input | 6 | Tag freed on port 1 |
| a_ps0 | output | 6 | Slot A first source tag |
| a_ps1 | output | 6 | Slot A second source tag |
| a_pdst | output | 6 | Slot A new destination tag |
| a_pold | output | 6 | Slot A previous destination tag |
| b_ps0 | output | 6 | Slot B first source tag |
| b_ps1 | output | 6 | Slot B second source tag |
| b_pdst | output | 6 | Slot B new destination tag |
| b_pold | output | 6 | Slot B previous destination tag |
| grp_stall | output | 1 | Group cannot be renamed this cycle |

## Verification
The rename path is driven with independent groups and with groups in which slot B reads slot A's destination through one or both sources. One group has slot B writing the same register as slot A, and some groups carry cleared valid bits. The independent groups check plain table lookup and lowest-first allocation. The dependent groups separate correct forwarding from stale table reads. Draining the pool to zero, then returning one or two tags, shows that the stall compares against the number of writing slots and not just against an empty pool. It also shows that returned tags are reused in ascending order.

// File: rtl/reg_renamer.sv
module reg_renamer #(
  parameter int NARCH = 32,
  parameter int NPHYS = 64,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grp_vld,
  input  logic          a_dst_vld,
  input  logic [AW-1:0] a_dst,
  input  logic          a_s0_vld,
  input  logic [AW-1:0] a_s0,
  input  logic          a_s1_vld,
  input  logic [AW-1:0] a_s1,
  input  logic          b_dst_vld,
  input  logic [AW-1:0] b_dst,
  input  logic          b_s0_vld,
  input  logic [AW-1:0] b_s0,
  input  logic          b_s1_vld,
  input  logic [AW-1:0] b_s1,
  input  logic          ret0_vld,
  input  logic [PW-1:0] ret0_tag,
  input  logic          ret1_vld,
  input  logic [PW-1:0] ret1_tag,
  output logic [PW-1:0] a_ps0,
  output logic [PW-1:0] a_ps1,
  output logic [PW-1:0] a_pdst,
  output logic [PW-1:0] a_pold,
  output logic [PW-1:0] b_ps0,
  output logic [PW-1:0] b_ps1,
  output logic [PW-1:0] b_pdst,
  output logic [PW-1:0] b_pold,
  output logic          grp_stall
);

  logic [NARCH-1:0][PW-1:0] map_q;
  logic [NPHYS-1:0]         free_q, free_nxt;
  logic [PW-1:0]            first, second;
  logic [PW:0]              nfree, need;
  logic                     fire;

  function automatic logic [PW-1:0] lowest(input logic [NPHYS-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPHYS - 1; i >= 0; i--)
      if (v[i]) r = PW'(i);
    return r;
  endfunction

  assign first  = lowest(free_q);
  assign second = lowest(free_q & ~(NPHYS'(1) << first));
  assign nfree  = (PW+1)'($countones(free_q));
  assign need   = (PW+1)'(a_dst_vld) + (PW+1)'(b_dst_vld);

  assign grp_stall = grp_vld && (nfree < need);
  assign fire      = grp_vld && !grp_stall;

  assign a_ps0  = a_s0_vld  ? map_q[a_s0]  : '0;
  assign a_ps1  = a_s1_vld  ? map_q[a_s1]  : '0;
  assign a_pdst = a_dst_vld ? first        : '0;
  assign a_pold = a_dst_vld ? map_q[a_dst] : '0;

  assign b_ps0  = !b_s0_vld ? '0 : (a_dst_vld && b_s0 == a_dst) ? a_pdst : map_q[b_s0];
  assign b_ps1  = !b_s1_vld ? '0 : (a_dst_vld && b_s1 == a_dst) ? a_pdst : map_q[b_s1];
  assign b_pdst = !b_dst_vld ? '0 : a_dst_vld ? second : first;
  assign b_pold = !b_dst_vld ? '0 : (a_dst_vld && b_dst == a_dst) ? a_pdst : map_q[b_dst];

  always_comb begin
    free_nxt = free_q;
    if (fire && a_dst_vld) free_nxt[a_pdst] = 1'b0;
    if (fire && b_dst_vld) free_nxt[b_pdst] = 1'b0;
    if (ret0_vld) free_nxt[ret0_tag] = 1'b1;
    if (ret1_vld) free_nxt[ret1_tag] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) map_q[i] <= PW'(i);
      for (int i = 0; i < NPHYS; i++) free_q[i] <= (i >= NARCH);
    end else begin
      free_q <= free_nxt;
      if (fire && a_dst_vld) map_q[a_dst] <= a_pdst;
      if (fire && b_dst_vld) map_q[b_dst] <= b_pdst;
    end
  end

  p_alloc_from_pool_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && a_dst_vld |-> free_q[a_pdst]);
  p_group_tags_differ_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && a_dst_vld && b_dst_vld |-> a_pdst != b_pdst);
  p_same_dst_last_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && a_dst_vld && b_dst_vld && a_dst == b_dst |=> map_q[$past(b_dst)] == $past(b_pdst));
  p_stall_freezes_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grp_stall |=> $stable(map_q));
  p_stall_needs_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_vld |-> !grp_stall);
  p_idle_freezes_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_vld |=> $stable(map_q));
  p_return_in_use_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret0_vld |-> !free_q[ret0_tag]);
  p_return_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret0_vld && ret1_vld |-> ret0_tag != ret1_tag);

endmodule

// File: tb/sim_reg_renamer.sv
module sim_reg_renamer;
  logic clk = 0, rst_n = 0;
  logic grp_vld = 0;
  logic a_dst_vld = 0, a_s0_vld = 0, a_s1_vld = 0, b_dst_vld = 0, b_s0_vld = 0, b_s1_vld = 0;
  logic [4:0] a_dst = 0, a_s0 = 0, a_s1 = 0, b_dst = 0, b_s0 = 0, b_s1 = 0;
  logic ret0_vld = 0, ret1_vld = 0;
  logic [5:0] ret0_tag = 0, ret1_tag = 0;
  logic [5:0] a_ps0, a_ps1, a_pdst, a_pold, b_ps0, b_ps1, b_pdst, b_pold;
  logic grp_stall;

  int n_run = 0, n_fail = 0;
  int bm [32];
  bit bf [64];
  int last_apold, last_bpold;
  int saved [32];

  always #10 clk = ~clk;

  reg_renamer u0 (.*);

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int nfree();
    int c = 0;
    for (int i = 0; i < 64; i++) c += bf[i];
    return c;
  endfunction

  function automatic int lowest(input int skip);
    for (int i = 0; i < 64; i++) if (bf[i] && i != skip) return i;
    return 0;
  endfunction

  task automatic grp(input bit v, input bit adv, input int ad, input bit a0v, input int a0,
                     input bit a1v, input int a1, input bit bdv, input int bd, input bit b0v,
                     input int b0, input bit b1v, input int b1, input string req);
    int need, ea, eb, f1;
    bit st;
    need = v ? int'(adv) + int'(bdv) : 0;
    st = v && need > nfree();
    f1 = lowest(-1);
    ea = adv ? f1 : 0;
    eb = !bdv ? 0 : adv ? lowest(f1) : f1;
    @(negedge clk);
    grp_vld = v; a_dst_vld = adv; a_dst = ad[4:0]; a_s0_vld = a0v; a_s0 = a0[4:0];
    a_s1_vld = a1v; a_s1 = a1[4:0]; b_dst_vld = bdv; b_dst = bd[4:0]; b_s0_vld = b0v;
    b_s0 = b0[4:0]; b_s1_vld = b1v; b_s1 = b1[4:0];
    #1;
    chk(req, "stall", int'(grp_stall), int'(st));
    chk(req, "a_ps0", int'(a_ps0), a0v ? bm[a0] : 0);
    chk(req, "a_ps1", int'(a_ps1), a1v ? bm[a1] : 0);
    chk(req, "b_ps0", int'(b_ps0), !b0v ? 0 : (adv && b0 == ad) ? ea : bm[b0]);
    chk(req, "b_ps1", int'(b_ps1), !b1v ? 0 : (adv && b1 == ad) ? ea : bm[b1]);
    if (!st) begin
      chk(req, "a_pdst", int'(a_pdst), ea);
      chk(req, "b_pdst", int'(b_pdst), eb);
      chk(req, "a_pold", int'(a_pold), adv ? bm[ad] : 0);
      chk(req, "b_pold", int'(b_pold), !bdv ? 0 : (adv && bd == ad) ? ea : bm[bd]);
    end
    last_apold = int'(a_pold);
    last_bpold = int'(b_pold);
    @(posedge clk);
    if (v && !st) begin
      if (adv) begin bf[ea] = 0; bm[ad] = ea; end
      if (bdv) begin bf[eb] = 0; bm[bd] = eb; end
    end
    @(negedge clk);
    grp_vld = 0;
  endtask

  task automatic ret(input bit v0, input int t0, input bit v1, input int t1);
    @(negedge clk);
    ret0_vld = v0; ret0_tag = t0[5:0]; ret1_vld = v1; ret1_tag = t1[5:0];
    @(posedge clk);
    if (v0) bf[t0] = 1;
    if (v1) bf[t1] = 1;
    @(negedge clk);
    ret0_vld = 0; ret1_vld = 0;
  endtask

  task automatic lookup_all(input string req);
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      a_s0_vld = 1; a_s0 = r[4:0];
      #1 chk(req, "table lookup", int'(a_ps0), bm[r]);
    end
    a_s0_vld = 0;
  endtask

  task automatic t_reset();
    chk("R1", "free count", nfree(), 32);
    lookup_all("R1");
    grp(1, 1, 7, 0, 0, 0, 0, 1, 8, 0, 0, 0, 0, "R1");
    chk("R1", "first alloc", last_apold, 7);
  endtask

  task automatic t_basic();
    grp(1, 1, 3, 1, 1, 1, 2, 1, 4, 1, 5, 1, 6, "R2 R3 R4");
    grp(1, 0, 0, 1, 3, 0, 9, 1, 10, 1, 4, 0, 0, "R2 R3");
    grp(1, 1, 3, 1, 3, 1, 4, 0, 0, 1, 3, 1, 7, "R4");
  endtask

  task automatic t_bypass();
    grp(1, 1, 12, 1, 12, 0, 0, 0, 0, 1, 12, 1, 12, "R5");
    grp(1, 1, 13, 1, 1, 1, 2, 1, 14, 1, 13, 1, 1, "R5");
    grp(1, 0, 13, 0, 0, 0, 0, 1, 15, 1, 13, 1, 13, "R5");
  endtask

  task automatic t_same_dst();
    grp(1, 1, 20, 1, 20, 0, 0, 1, 20, 1, 20, 0, 0, "R6");
    grp(1, 0, 0, 1, 20, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
  endtask

  task automatic t_idle();
    grp(0, 1, 21, 1, 22, 1, 23, 1, 22, 1, 21, 1, 23, "R9");
    lookup_all("R9");
  endtask

  task automatic t_drain();
    int k = 0;
    while (nfree() >= 2) begin
      grp(1, 1, k % 32, 0, 0, 0, 0, 1, (k + 16) % 32, 0, 0, 0, 0, "R7");
      saved[2*k] = last_apold;
      saved[2*k+1] = last_bpold;
      k++;
    end
    if (nfree() == 1) grp(1, 1, 30, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    chk("R7", "pool empty", nfree(), 0);
    grp(1, 1, 5, 1, 5, 0, 0, 1, 6, 1, 6, 0, 0, "R7");
    grp(1, 0, 0, 0, 0, 0, 0, 1, 9, 1, 9, 0, 0, "R7");
    grp(0, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    lookup_all("R7");
  endtask

  task automatic t_return();
    ret(1, saved[1], 1, saved[0]);
    chk("R8", "pool after return", nfree(), 2);
    grp(1, 1, 2, 0, 0, 0, 0, 1, 11, 0, 0, 0, 0, "R8");
    ret(1, saved[2], 0, 0);
    grp(1, 1, 4, 0, 0, 0, 0, 1, 8, 0, 0, 0, 0, "R7 R8");
    grp(1, 0, 0, 0, 0, 0, 0, 1, 8, 1, 8, 0, 0, "R8");
    chk("R8", "pool after reuse", nfree(), 0);
    lookup_all("R8");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) bm[i] = i;
    for (int i = 0; i < 64; i++) bf[i] = (i >= 32);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_basic();
    t_bypass();
    t_same_dst();
    t_idle();
    t_drain();
    t_return();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule